// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block drives an external successive-approximation converter core through a start/done handshake. Its settings arrive as plain configuration inputs mirroring a control register image: a power-down bit, a run (start-of-conversion) enable, a one-shot mode bit with a separate trigger strobe, a fixed-channel mode bit with its channel number, a per-channel enable mask for scanning, an even clock-divider value and a 32-bit idle interval.

While running, the sequencer chooses the next channel, pulses a start to the core, waits for the core's done flag, forwards the sample and its channel index downstream as a single-cycle result, then idles for the programmed interval before the next conversion. It also produces a divided sample clock for the core. The scan mask is captured when the run enable rises, so edits to it only take effect after run is cleared and set again.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In scan mode (fixed-mode bit 0) channels are converted in ascending index order over the captured mask, wrapping from the highest enabled channel to the lowest, starting with the lowest after run rises; bit i of the mask enables channel i. An empty captured mask issues no conversion.
- R2: In fixed mode (fixed-mode bit 1) every conversion uses the channel on `cfg_fixed_chan` and the mask is ignored.
- R3: A conversion is only started while `cfg_run` is 1; once it is cleared no new conversion starts, and one already in flight still delivers its result.
- R4: The mask is captured on the cycle `cfg_run` rises; later mask changes are ignored until run is cleared and set again. The first start appears no earlier than two cycles after the rise.
- R5: With one-shot mode set, a conversion starts only if the trigger is pending; a one-cycle pulse on `cfg_shot_req` sets `shot_pending`, which clears when that conversion is issued (a pulse in the same cycle wins).
- R6: `core_clk` toggles once every D/2+1 clock cycles, D being the last even value seen on `cfg_div` (reset 0); odd values are ignored.
- R7: After a result cycle, the next `core_start` comes exactly G+1 cycles later, G being `cfg_gap`.
- R8: `core_pd` follows `cfg_pwr_dn`; while it is set no start or result is produced, any conversion in flight is abandoned and `core_clk` is held low.
- R9: The cycle after `core_done` is seen during a conversion, `res_valid` is high for one cycle with `res_data` equal to the core sample and `res_chan` equal to the converted channel.
- R10: `core_start` is a one-cycle pulse; `core_chan` changes only together with a start and holds until the next.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwr_dn | input | 1 | Power-down request |
| cfg_run | input | 1 | Start-of-conversion enable |
| cfg_oneshot_mode | input | 1 | 1: one conversion per trigger; 0: continuous |
| cfg_shot_req | input | 1 | One-cycle strobe of the trigger bit write |
| cfg_fixed_mode | input | 1 | 1: fixed channel; 0: scan the mask |
| cfg_fixed_chan | input | CH_W (3) | Channel used in fixed mode |
| cfg_chan_mask | input | NCH (8) | Per-channel scan enables |
| cfg_div | input | DIV_W (4) | Sample clock divider, even values only |
| cfg_gap | input | GAP_W (32) | Idle cycles between conversions |
| core_done | input | 1 | Core conversion complete |
| core_data | input | DATA_W (10) | Core sample |
| core_pd | output | 1 | Core power-down |
| core_clk | output | 1 | Divided sample clock |
| core_start | output | 1 | Conversion start pulse |
| core_chan | output | CH_W (3) | Channel being converted |
| shot_pending | output | 1 | One-shot trigger pending |
| res_valid | output | 1 | Result pulse |
| res_data | output | DATA_W (10) | Result sample |
| res_chan | output | CH_W (3) | Result channel |

## Verification
The assertions take for granted that the core raises `core_done` for a single cycle and only once per start, some cycles after it, and that `cfg_shot_req` is a one-cycle strobe. The bench's core model answers each start after a fixed latency with one done pulse, drops a pending answer when power-down is raised, and the stimulus drives the trigger only as single-cycle pulses, so the result-after-done and one-shot properties stay within what the design promises.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_BUSY = 2'd1,
      SQ_GAP  = 2'd2
   } sq_state_e;

   localparam int unsigned DEF_NCH    = 8;
   localparam int unsigned DEF_DATA_W = 10;
   localparam int unsigned DEF_DIV_W  = 4;
   localparam int unsigned DEF_GAP_W  = 32;

endpackage

// File: rtl/adc_seq_clkdiv.sv
`timescale 1ns/1ps
module adc_seq_clkdiv #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd,
   input  logic [DIV_W-1:0] div_in,
   output logic             sclk
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] half;

   assign half = div_q >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         phase_q <= '0;
         sclk    <= 1'b0;
      end else begin
         // only even settings are accepted; odd ones keep the last good value
         if (!div_in[0])
            div_q <= div_in;
         if (pd) begin
            phase_q <= '0;
            sclk    <= 1'b0;
         end else if (phase_q >= half) begin
            phase_q <= '0;
            sclk    <= ~sclk;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/adc_seq_chansel.sv
`timescale 1ns/1ps
module adc_seq_chansel #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CH_W = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [NCH-1:0]  mask_in,
   input  logic            adv,
   output logic            run_q,
   output logic [NCH-1:0]  mask_q,
   output logic            any_en,
   output logic [CH_W-1:0] next_chan
);

   localparam logic [CH_W-1:0] TOP_IDX = CH_W'(NCH - 1);

   logic [CH_W-1:0] last_q;
   logic [NCH-1:0]  above;
   logic [CH_W-1:0] lo_above;
   logic [CH_W-1:0] lo_all;

   for (genvar i = 0; i < NCH; i++) begin : g_above
      localparam logic [CH_W-1:0] IDX = CH_W'(i);
      assign above[i] = mask_q[i] & (IDX > last_q);
   end

   always_comb begin
      lo_above = '0;
      lo_all   = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (above[i])
            lo_above = CH_W'(i);
         if (mask_q[i])
            lo_all = CH_W'(i);
      end
   end

   assign any_en    = |mask_q;
   assign next_chan = (|above) ? lo_above : lo_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mask_q <= '0;
         last_q <= TOP_IDX;
      end else begin
         run_q <= run;
         if (run && !run_q) begin
            mask_q <= mask_in;
            last_q <= TOP_IDX;
         end else if (adv) begin
            last_q <= next_chan;
         end
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W   = 3,
   parameter int unsigned DATA_W = 10,
   parameter int unsigned GAP_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd,
   input  logic              run,
   input  logic              run_q,
   input  logic              oneshot_mode,
   input  logic              shot_req,
   input  logic              fixed_mode,
   input  logic [CH_W-1:0]   fixed_chan,
   input  logic              any_en,
   input  logic [CH_W-1:0]   next_chan,
   input  logic [GAP_W-1:0]  gap,
   input  logic              core_done,
   input  logic [DATA_W-1:0] core_data,
   output logic              adv,
   output logic              core_start,
   output logic [CH_W-1:0]   core_chan,
   output logic              shot_pending,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CH_W-1:0]   res_chan
);

   sq_state_e        state_q;
   logic [GAP_W-1:0] gap_cnt;
   logic             issue;
   logic [CH_W-1:0]  sel_chan;

   assign issue = !pd && (state_q == SQ_IDLE) && run && run_q
                  && (fixed_mode || any_en)
                  && (!oneshot_mode || shot_pending);
   assign sel_chan = fixed_mode ? fixed_chan : next_chan;
   assign adv      = issue && !fixed_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SQ_IDLE;
         gap_cnt      <= '0;
         core_start   <= 1'b0;
         core_chan    <= '0;
         shot_pending <= 1'b0;
         res_valid    <= 1'b0;
         res_data     <= '0;
         res_chan     <= '0;
      end else begin
         core_start   <= issue;
         res_valid    <= 1'b0;
         shot_pending <= shot_req | (shot_pending & ~issue);
         if (issue)
            core_chan <= sel_chan;
         if (pd) begin
            state_q <= SQ_IDLE;
         end else begin
            unique case (state_q)
               SQ_IDLE: if (issue) state_q <= SQ_BUSY;
               SQ_BUSY: if (core_done) begin
                  res_valid <= 1'b1;
                  res_data  <= core_data;
                  res_chan  <= core_chan;
                  gap_cnt   <= gap;
                  state_q   <= (gap == '0) ? SQ_IDLE : SQ_GAP;
               end
               SQ_GAP: begin
                  if (gap_cnt == GAP_W'(1))
                     state_q <= SQ_IDLE;
                  else
                     gap_cnt <= gap_cnt - 1'b1;
               end
               default: state_q <= SQ_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned NCH    = DEF_NCH,
   parameter int unsigned CH_W   = $clog2(NCH),
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned DIV_W  = DEF_DIV_W,
   parameter int unsigned GAP_W  = DEF_GAP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pwr_dn,
   input  logic              cfg_run,
   input  logic              cfg_oneshot_mode,
   input  logic              cfg_shot_req,
   input  logic              cfg_fixed_mode,
   input  logic [CH_W-1:0]   cfg_fixed_chan,
   input  logic [NCH-1:0]    cfg_chan_mask,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              core_done,
   input  logic [DATA_W-1:0] core_data,
   output logic              core_pd,
   output logic              core_clk,
   output logic              core_start,
   output logic [CH_W-1:0]   core_chan,
   output logic              shot_pending,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CH_W-1:0]   res_chan
);

   if ((1 << CH_W) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two matching CH_W");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (GAP_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("GAP_W and DATA_W must be positive");
   end

   logic            run_q;
   logic [NCH-1:0]  mask_latched;
   logic            any_en;
   logic [CH_W-1:0] next_chan;
   logic            adv;

   assign core_pd = cfg_pwr_dn;

   adc_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd     (cfg_pwr_dn),
      .div_in (cfg_div),
      .sclk   (core_clk)
   );

   adc_seq_chansel #(.NCH(NCH), .CH_W(CH_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (cfg_run),
      .mask_in   (cfg_chan_mask),
      .adv       (adv),
      .run_q     (run_q),
      .mask_q    (mask_latched),
      .any_en    (any_en),
      .next_chan (next_chan)
   );

   adc_seq_fsm #(.CH_W(CH_W), .DATA_W(DATA_W), .GAP_W(GAP_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pd           (cfg_pwr_dn),
      .run          (cfg_run),
      .run_q        (run_q),
      .oneshot_mode (cfg_oneshot_mode),
      .shot_req     (cfg_shot_req),
      .fixed_mode   (cfg_fixed_mode),
      .fixed_chan   (cfg_fixed_chan),
      .any_en       (any_en),
      .next_chan    (next_chan),
      .gap          (cfg_gap),
      .core_done    (core_done),
      .core_data    (core_data),
      .adv          (adv),
      .core_start   (core_start),
      .core_chan    (core_chan),
      .shot_pending (shot_pending),
      .res_valid    (res_valid),
      .res_data     (res_data),
      .res_chan     (res_chan)
   );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_pwr_dn,
   input logic            cfg_run,
   input logic            cfg_oneshot_mode,
   input logic            cfg_fixed_mode,
   input logic [CH_W-1:0] cfg_fixed_chan,
   input logic            core_done,
   input logic            core_start,
   input logic [CH_W-1:0] core_chan,
   input logic            res_valid,
   input logic            shot_pending,
   input logic [NCH-1:0]  mask_latched
);

   assert_scan_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      core_start && !$past(cfg_fixed_mode) |-> mask_latched[core_chan]);

   assert_fixed_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_start && $past(cfg_fixed_mode) |-> core_chan == $past(cfg_fixed_chan));

   assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> $past(cfg_run));

   assert_shot_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      core_start && $past(cfg_oneshot_mode) |-> $past(shot_pending));

   assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_pwr_dn) |-> !core_start && !res_valid);

   assert_res_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(core_done));

   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_pwr_dn       (cfg_pwr_dn),
   .cfg_run          (cfg_run),
   .cfg_oneshot_mode (cfg_oneshot_mode),
   .cfg_fixed_mode   (cfg_fixed_mode),
   .cfg_fixed_chan   (cfg_fixed_chan),
   .core_done        (core_done),
   .core_start       (core_start),
   .core_chan        (core_chan),
   .res_valid        (res_valid),
   .shot_pending     (shot_pending),
   .mask_latched     (mask_latched)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_pwr_dn = 1'b0;
   logic        cfg_run = 1'b0;
   logic        cfg_oneshot_mode = 1'b0;
   logic        cfg_shot_req = 1'b0;
   logic        cfg_fixed_mode = 1'b0;
   logic [2:0]  cfg_fixed_chan = '0;
   logic [7:0]  cfg_chan_mask = '0;
   logic [3:0]  cfg_div = '0;
   logic [31:0] cfg_gap = '0;
   logic        core_done = 1'b0;
   logic [9:0]  core_data = '0;
   logic        core_pd, core_clk, core_start, shot_pending, res_valid;
   logic [2:0]  core_chan, res_chan;
   logic [9:0]  res_data;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 0;

   int q_res_chan[$];
   int q_res_cyc[$];
   int q_start_cyc[$];
   int q_tog_cyc[$];

   always #5 clk = ~clk;

   adc_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_pwr_dn(cfg_pwr_dn), .cfg_run(cfg_run),
      .cfg_oneshot_mode(cfg_oneshot_mode), .cfg_shot_req(cfg_shot_req),
      .cfg_fixed_mode(cfg_fixed_mode), .cfg_fixed_chan(cfg_fixed_chan),
      .cfg_chan_mask(cfg_chan_mask), .cfg_div(cfg_div), .cfg_gap(cfg_gap),
      .core_done(core_done), .core_data(core_data), .core_pd(core_pd),
      .core_clk(core_clk), .core_start(core_start), .core_chan(core_chan),
      .shot_pending(shot_pending), .res_valid(res_valid), .res_data(res_data),
      .res_chan(res_chan)
   );

   task automatic check(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int  m_state = 0;   // 0 idle, 1 converting, 2 waiting
   int  m_cnt = 0;
   int  m_last = 7;
   int  m_mask = 0;
   bit  m_run_q = 0;
   bit  m_pend = 0;
   int  m_div = 0;
   int  m_ph = 0;
   bit  m_sclk = 0;
   bit  e_start = 0;
   int  e_chan = 0;
   bit  e_valid = 0;
   int  e_data = 0;
   int  e_rchan = 0;

   function automatic int next_enabled(int mask, int last);
      for (int k = 1; k <= 8; k++) begin
         int c = (last + k) % 8;
         if (((mask >> c) & 1) == 1) return c;
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_last = 7; m_mask = 0; m_run_q = 0;
         m_pend = 0; m_div = 0; m_ph = 0; m_sclk = 0;
         e_start = 0; e_chan = 0; e_valid = 0; e_data = 0; e_rchan = 0;
      end else begin
         bit issue;
         issue = 0;
         if (cfg_pwr_dn) begin
            m_ph = 0; m_sclk = 0;
         end else if (m_ph >= m_div / 2) begin
            m_ph = 0; m_sclk = !m_sclk;
         end else begin
            m_ph++;
         end
         if (cfg_div % 2 == 0) m_div = cfg_div;

         e_start = 0;
         e_valid = 0;
         if (cfg_pwr_dn) begin
            m_state = 0;
         end else if (m_state == 0) begin
            if (cfg_run && m_run_q && (cfg_fixed_mode || m_mask != 0)
                && (!cfg_oneshot_mode || m_pend)) begin
               issue = 1;
               e_start = 1;
               if (cfg_fixed_mode) e_chan = cfg_fixed_chan;
               else begin
                  e_chan = next_enabled(m_mask, m_last);
                  m_last = e_chan;
               end
               m_state = 1;
            end
         end else if (m_state == 1) begin
            if (core_done) begin
               e_valid = 1; e_data = core_data; e_rchan = e_chan;
               if (cfg_gap == 0) m_state = 0;
               else begin m_state = 2; m_cnt = cfg_gap; end
            end
         end else begin
            if (m_cnt <= 1) m_state = 0;
            else m_cnt--;
         end
         if (cfg_shot_req) m_pend = 1;
         else if (issue) m_pend = 0;
         if (cfg_run && !m_run_q) begin
            m_mask = cfg_chan_mask; m_last = 7;
         end
         m_run_q = cfg_run;
      end
   end

   // ---------------- per-cycle comparison and logging ----------------
   bit prev_sclk = 0;
   initial begin
      @(posedge clk);
      forever begin
         @(negedge clk);
         check(core_start === e_start, "R10", "core_start", int'(core_start), int'(e_start));
         check(core_chan === 3'(e_chan), "R1", "core_chan", int'(core_chan), e_chan);
         check(res_valid === e_valid, "R9", "res_valid", int'(res_valid), int'(e_valid));
         if (e_valid) begin
            check(res_data === 10'(e_data), "R9", "res_data", int'(res_data), e_data);
            check(res_chan === 3'(e_rchan), "R9", "res_chan", int'(res_chan), e_rchan);
         end
         check(shot_pending === m_pend, "R5", "shot_pending", int'(shot_pending), int'(m_pend));
         check(core_clk === m_sclk, "R6", "core_clk", int'(core_clk), int'(m_sclk));
         check(core_pd === cfg_pwr_dn, "R8", "core_pd", int'(core_pd), int'(cfg_pwr_dn));
         if (core_start === 1'b1) q_start_cyc.push_back(cyc);
         if (res_valid === 1'b1) begin
            q_res_cyc.push_back(cyc);
            q_res_chan.push_back(int'(res_chan));
         end
         if (core_clk !== prev_sclk) q_tog_cyc.push_back(cyc);
         prev_sclk = core_clk;
      end
   end

   // ---------------- converter core emulation ----------------
   initial begin
      int countdown = 0;
      int seqn = 0;
      forever begin
         @(posedge clk); #1;
         core_done = 1'b0;
         if (countdown > 0) begin
            countdown--;
            if (countdown == 0) begin
               core_done = 1'b1;
               core_data = 10'((int'(core_chan) * 97 + seqn * 13) % 1024);
               seqn++;
            end
         end
         if (core_start === 1'b1) countdown = 3;
         if (cfg_pwr_dn) countdown = 0;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_logs();
      q_res_chan.delete(); q_res_cyc.delete(); q_start_cyc.delete(); q_tog_cyc.delete();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- directed stimulus ----------------
   initial begin
      int ns, nr, run_cyc;
      bit ok;
      wait_cyc(4);
      // R11: reset values
      check(core_start == 0 && res_valid == 0 && shot_pending == 0 && core_chan == 0
            && core_clk == 0 && res_data == 0 && res_chan == 0, "R11", "reset outputs", 1, 0);
      rst_n = 1'b1;
      wait_cyc(3);

      // R1 / R7 / R4: scan order, interval, first-start latency
      cfg_chan_mask = 8'b1010_0110; cfg_gap = 7; cfg_div = 4;
      clear_logs();
      cfg_run = 1'b1; run_cyc = cyc;
      wait_cyc(120);
      check(q_res_chan.size() >= 5, "R1", "scan result count", q_res_chan.size(), 5);
      if (q_res_chan.size() >= 5) begin
         check(q_res_chan[0] == 1, "R1", "scan 1st", q_res_chan[0], 1);
         check(q_res_chan[1] == 2, "R1", "scan 2nd", q_res_chan[1], 2);
         check(q_res_chan[2] == 5, "R1", "scan 3rd", q_res_chan[2], 5);
         check(q_res_chan[3] == 7, "R1", "scan 4th", q_res_chan[3], 7);
         check(q_res_chan[4] == 1, "R1", "scan wrap", q_res_chan[4], 1);
      end
      if (q_start_cyc.size() >= 2 && q_res_cyc.size() >= 1) begin
         check(q_start_cyc[1] - q_res_cyc[0] == 8, "R7", "gap 7 spacing",
               q_start_cyc[1] - q_res_cyc[0], 8);
         check(q_start_cyc[0] - run_cyc >= 2, "R4", "first start latency",
               q_start_cyc[0] - run_cyc, 2);
      end

      // R4: mask edits ignored until run is toggled
      cfg_chan_mask = 8'b0000_1001;
      clear_logs();
      wait_cyc(80);
      ok = (q_res_chan.size() > 0);
      foreach (q_res_chan[i])
         if (!(q_res_chan[i] inside {1, 2, 5, 7})) ok = 0;
      check(ok, "R4", "old mask still used", ok, 1);
      cfg_run = 1'b0;
      wait_cyc(20);
      clear_logs();
      cfg_run = 1'b1;
      wait_cyc(80);
      check(q_res_chan.size() >= 2, "R4", "new mask results", q_res_chan.size(), 2);
      if (q_res_chan.size() >= 2) begin
         check(q_res_chan[0] == 0, "R4", "new mask 1st", q_res_chan[0], 0);
         check(q_res_chan[1] == 3, "R4", "new mask 2nd", q_res_chan[1], 3);
      end

      // R7: zero interval
      cfg_run = 1'b0;
      wait_cyc(20);
      cfg_gap = 0;
      clear_logs();
      cfg_run = 1'b1;
      wait_cyc(40);
      if (q_start_cyc.size() >= 2 && q_res_cyc.size() >= 1)
         check(q_start_cyc[1] - q_res_cyc[0] == 1, "R7", "gap 0 spacing",
               q_start_cyc[1] - q_res_cyc[0], 1);
      else
         check(0, "R7", "gap 0 activity", q_start_cyc.size(), 2);

      // R3: clearing run while converting
      while (core_start !== 1'b1) wait_cyc(1);
      cfg_run = 1'b0;
      ns = q_start_cyc.size(); nr = q_res_cyc.size();
      wait_cyc(30);
      check(q_start_cyc.size() == ns + 1, "R3", "no start after stop", q_start_cyc.size(), ns + 1);
      check(q_res_cyc.size() == nr + 1, "R3", "in-flight result", q_res_cyc.size(), nr + 1);

      // R1: empty mask stays idle
      cfg_chan_mask = 8'h00; cfg_gap = 3;
      clear_logs();
      cfg_run = 1'b1;
      wait_cyc(60);
      check(q_start_cyc.size() == 0, "R1", "empty mask starts", q_start_cyc.size(), 0);
      cfg_run = 1'b0;
      wait_cyc(5);

      // R2: fixed channel ignores mask
      cfg_fixed_mode = 1'b1; cfg_fixed_chan = 3'd6;
      clear_logs();
      cfg_run = 1'b1;
      wait_cyc(30);
      cfg_chan_mask = 8'hFF;
      wait_cyc(30);
      ok = (q_res_chan.size() >= 3);
      foreach (q_res_chan[i]) if (q_res_chan[i] != 6) ok = 0;
      check(ok, "R2", "fixed channel results", ok, 1);
      cfg_run = 1'b0;
      wait_cyc(20);
      cfg_fixed_mode = 1'b0;

      // R5: one-shot mode
      cfg_oneshot_mode = 1'b1; cfg_chan_mask = 8'h10;
      clear_logs();
      cfg_run = 1'b1;
      wait_cyc(50);
      check(q_start_cyc.size() == 0, "R5", "no start without trigger", q_start_cyc.size(), 0);
      cfg_shot_req = 1'b1;
      wait_cyc(1);
      cfg_shot_req = 1'b0;
      check(shot_pending == 1'b1, "R5", "trigger pending", int'(shot_pending), 1);
      wait_cyc(40);
      check(q_res_chan.size() == 1, "R5", "one result per trigger", q_res_chan.size(), 1);
      if (q_res_chan.size() == 1)
         check(q_res_chan[0] == 4, "R5", "one-shot channel", q_res_chan[0], 4);
      check(shot_pending == 1'b0, "R5", "trigger self-clear", int'(shot_pending), 0);
      cfg_run = 1'b0; cfg_oneshot_mode = 1'b0;
      wait_cyc(10);

      // R6: divider, including an ignored odd value
      cfg_div = 6;
      wait_cyc(10);
      clear_logs();
      wait_cyc(60);
      if (q_tog_cyc.size() >= 4)
         check(q_tog_cyc[3] - q_tog_cyc[2] == 4, "R6", "div 6 half period", q_tog_cyc[3] - q_tog_cyc[2], 4);
      cfg_div = 5;
      clear_logs();
      wait_cyc(60);
      if (q_tog_cyc.size() >= 4)
         check(q_tog_cyc[3] - q_tog_cyc[2] == 4, "R6", "odd div ignored", q_tog_cyc[3] - q_tog_cyc[2], 4);
      cfg_div = 0;
      wait_cyc(5);
      clear_logs();
      wait_cyc(20);
      if (q_tog_cyc.size() >= 4)
         check(q_tog_cyc[3] - q_tog_cyc[2] == 1, "R6", "div 0 half period", q_tog_cyc[3] - q_tog_cyc[2], 1);

      // R8: power-down
      cfg_chan_mask = 8'hFF; cfg_gap = 2;
      cfg_run = 1'b1;
      wait_cyc(15);
      cfg_pwr_dn = 1'b1;
      wait_cyc(1);
      clear_logs();
      wait_cyc(40);
      check(q_start_cyc.size() == 0 && q_res_cyc.size() == 0, "R8", "activity in power-down",
            q_start_cyc.size() + q_res_cyc.size(), 0);
      check(core_clk == 1'b0 && core_pd == 1'b1, "R8", "clock low, core off",
            int'(core_clk) + 2 * int'(core_pd), 2);
      cfg_pwr_dn = 1'b0;
      wait_cyc(40);
      check(q_start_cyc.size() > 0, "R8", "resume after power-up", q_start_cyc.size(), 1);
      cfg_run = 1'b0;
      wait_cyc(20);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule